// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital side of a 100-tap digital potentiometer. Three slow control pins are driven from outside the chip and are not related to the system clock: an active-low select, a direction level and an active-low step strobe. The block samples them on the system clock and keeps the wiper position in a 7-bit counter. It decodes that position into a one-hot tap enable that drives the switch network of the resistor string.

Each falling edge of the step strobe moves the wiper one tap while the part is selected. The direction level sampled at that edge picks up or down, and the count stops at either end of the range. A modelled non-volatile word keeps a saved position. Releasing select while the strobe is high copies the position into that word. While the copy is in progress a busy flag holds for a fixed number of cycles, and after it the block reports standby until it is selected again. Every warm reset reloads the wiper from the saved word. The saved word is cleared to a parameter value only by the cold power-on reset.

The block carries no data stream. All pins are plain control and status levels, so no valid/ready handshake or back-pressure applies.

Top module: `wiper_ctrl`

## Requirements
- R1: After a cold reset (`por_n` and `rst_n` both low), the wiper position equals `NV_INIT` (default 0), `busy` is 0 and `standby` is 0.
- R2: A falling edge of `step_n_pin` while selected, with `dir_pin` high, raises the position by one.
- R3: A falling edge of `step_n_pin` while selected, with `dir_pin` low, lowers the position by one.
- R4: While `sel_n_pin` is high, step edges leave the position unchanged.
- R5: The position never leaves 0..NUM_TAPS-1. Stepping up at NUM_TAPS-1 (99) or down at 0 leaves it where it is.
- R6: `tap_sel` has exactly one bit set, and that bit's index equals `wiper_pos`.
- R7: A low-to-high change of `sel_n_pin` while `step_n_pin` is high saves the position into the non-volatile word. `busy` is then high for exactly `STORE_CYCLES` consecutive cycles.
- R8: A low-to-high change of `sel_n_pin` while `step_n_pin` is low saves nothing and does not raise `busy`. The saved word keeps its old value.
- R9: When a save finishes with select released, `standby` goes to 1 and stays there until `sel_n_pin` goes low. `standby` is never 1 while `busy` is 1.
- R10: While `busy` is high the select pin is ignored, so step edges during a save leave the position unchanged.
- R11: A warm reset (`rst_n` low, `por_n` high) reloads the position from the saved word.
- R12: A rising edge of `step_n_pin` never moves the wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous warm reset, active low; reloads the wiper from the saved word |
| por_n | input | 1 | Synchronous power-on reset, active low; sets the saved word to NV_INIT |
| sel_n_pin | input | 1 | Select pin, active low, asynchronous |
| dir_pin | input | 1 | Direction level: 1 = up, 0 = down, asynchronous |
| step_n_pin | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| tap_sel | output | NUM_TAPS | One-hot tap enable |
| wiper_pos | output | POS_W | Current wiper position |
| busy | output | 1 | Save in progress |
| standby | output | 1 | Low-power state after a save, until selected |

## Verification
The assertions assume that both resets are held for at least two clock cycles at start-up, so that the saved word is defined before the wiper loads from it. They also assume that each pin level stays put for at least two clock cycles, so that the synchronizers see every edge exactly once. The stimulus changes pins only on falling clock edges and holds every level for at least two cycles. It asserts the power-on reset together with the warm reset for several cycles, and it gives `dir_pin` its new value well before the step edge that uses it.

// File: rtl/wc_pkg.sv
package wc_pkg;
  // Synchronizer depth for the asynchronous pins
  localparam int SYNC_STAGES = 2;

  // Decoded pin events, valid for one clock cycle
  typedef struct packed {
    logic sel_act;    // select pin currently low
    logic sel_rise;   // select released this cycle
    logic step_fall;  // strobe falling edge this cycle
    logic step_hi;    // strobe level is high
    logic dir_up;     // direction level
  } pin_evt_t;
endpackage

// File: rtl/wc_sync.sv
module wc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/wc_pin_front.sv
module wc_pin_front
  import wc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n_pin,
  input  logic     dir_pin,
  input  logic     step_n_pin,
  output pin_evt_t evt
);
  // bit 2: select, bit 1: direction, bit 0: strobe
  logic [2:0] raw;
  logic [2:0] synced;
  logic       sel_prev;
  logic       step_prev;

  assign raw = {sel_n_pin, dir_pin, step_n_pin};

  wc_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b101)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(raw),
    .q_sync (synced)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_prev  <= 1'b1;
      step_prev <= 1'b1;
    end else begin
      sel_prev  <= synced[2];
      step_prev <= synced[0];
    end
  end

  always_comb begin
    evt.sel_act   = ~synced[2];
    evt.sel_rise  = ~sel_prev & synced[2];
    evt.step_fall = step_prev & ~synced[0];
    evt.step_hi   = synced[0];
    evt.dir_up    = synced[1];
  end
endmodule

// File: rtl/wc_store_seq.sv
module wc_store_seq #(
  parameter int POS_W = 7,
  parameter int STORE_CYCLES = 64,
  parameter int NV_INIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             sel_act,
  input  logic             sel_rise,
  input  logic             step_hi,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nv_word,
  output logic             busy,
  output logic             standby
);
  localparam int CW = $clog2(STORE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(STORE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] remain;
  logic          do_store;

  assign busy     = (remain != '0);
  assign do_store = sel_rise & step_hi & ~busy;

  // Modelled non-volatile cell: only the power-on reset clears it
  always_ff @(posedge clk) begin
    if (!por_n)        nv_word <= POS_W'(NV_INIT);
    else if (do_store) nv_word <= pos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        remain <= '0;
    else if (do_store) remain <= LOAD;
    else if (busy)     remain <= remain - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               standby <= 1'b0;
    else if (remain == LAST)  standby <= ~sel_act;
    else if (!busy && sel_act) standby <= 1'b0;
  end
endmodule

// File: rtl/wc_wiper.sv
module wc_wiper #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] nv_word,
  input  logic             step_en,
  input  logic             dir_up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP = POS_W'(NUM_TAPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= nv_word;
    end else if (step_en) begin
      if (dir_up) begin
        if (pos != TOP) pos <= pos + 1'b1;
      end else begin
        if (pos != '0) pos <= pos - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wc_tap_decode.sv
module wc_tap_decode #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] tap_sel
);
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos == POS_W'(i));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wc_pkg::*;
#(
  parameter int NUM_TAPS = 100,
  parameter int STORE_CYCLES = 64,
  parameter int NV_INIT = 0,
  localparam int POS_W = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_n,
  input  logic                sel_n_pin,
  input  logic                dir_pin,
  input  logic                step_n_pin,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic [POS_W-1:0]    wiper_pos,
  output logic                busy,
  output logic                standby
);
  pin_evt_t         evt;
  logic [POS_W-1:0] nv_word;
  logic             step_en;

  wc_pin_front u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_pin (sel_n_pin),
    .dir_pin   (dir_pin),
    .step_n_pin(step_n_pin),
    .evt       (evt)
  );

  wc_store_seq #(
    .POS_W       (POS_W),
    .STORE_CYCLES(STORE_CYCLES),
    .NV_INIT     (NV_INIT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_n   (por_n),
    .sel_act (evt.sel_act),
    .sel_rise(evt.sel_rise),
    .step_hi (evt.step_hi),
    .pos     (wiper_pos),
    .nv_word (nv_word),
    .busy    (busy),
    .standby (standby)
  );

  // A select held during a save does not count until the save ends
  assign step_en = evt.step_fall & evt.sel_act & ~busy;

  wc_wiper #(
    .NUM_TAPS(NUM_TAPS),
    .POS_W   (POS_W)
  ) u_wiper (
    .clk    (clk),
    .rst_n  (rst_n),
    .nv_word(nv_word),
    .step_en(step_en),
    .dir_up (evt.dir_up),
    .pos    (wiper_pos)
  );

  wc_tap_decode #(
    .NUM_TAPS(NUM_TAPS),
    .POS_W   (POS_W)
  ) u_decode (
    .pos    (wiper_pos),
    .tap_sel(tap_sel)
  );
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int NUM_TAPS = 100,
  parameter int POS_W = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                por_n,
  input logic [NUM_TAPS-1:0] tap_sel,
  input logic [POS_W-1:0]    wiper_pos,
  input logic                busy,
  input logic                standby,
  input logic [POS_W-1:0]    nv_word
);
  AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $countones(tap_sel) == 1); // R6
  AST_TAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    tap_sel[wiper_pos] == 1'b1); // R6
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wiper_pos < POS_W'(NUM_TAPS)); // R5
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wiper_pos != $past(wiper_pos)) |->
      (wiper_pos == $past(wiper_pos) + 1'b1 || wiper_pos == $past(wiper_pos) - 1'b1)); // R2
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    busy |=> $stable(wiper_pos)); // R10
  AST_STANDBY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    standby |-> !busy); // R9
  AST_SAVE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (nv_word != $past(nv_word)) |-> $rose(busy)); // R7
endmodule

bind wiper_ctrl wc_checker #(
  .NUM_TAPS(NUM_TAPS),
  .POS_W   (POS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_n    (por_n),
  .tap_sel  (tap_sel),
  .wiper_pos(wiper_pos),
  .busy     (busy),
  .standby  (standby),
  .nv_word  (nv_word)
);

// File: tb/sim_wiper_ctrl.sv
module sim_wiper_ctrl;
  localparam int NT = 100;
  localparam int SC = 20;
  localparam int PW = $clog2(NT);

  logic clk = 1'b0;
  logic rst_n, por_n, sel_n, dir, step_n;
  logic [NT-1:0] tap_sel;
  logic [PW-1:0] pos;
  logic busy, standby;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_ctrl #(.NUM_TAPS(NT), .STORE_CYCLES(SC), .NV_INIT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sel_n_pin(sel_n),
    .dir_pin(dir), .step_n_pin(step_n), .tap_sel(tap_sel),
    .wiper_pos(pos), .busy(busy), .standby(standby)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lo, input int hi);
    step_n = 1'b0; idle(lo);
    step_n = 1'b1; idle(hi);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse(3, 3);
    idle(4);
  endtask

  task automatic check_tap(input string req, input int exp_pos);
    check(req, $countones(tap_sel), 1);
    check(req, int'(tap_sel[exp_pos]), 1);
  endtask

  task automatic warm_reset();
    rst_n = 1'b0; idle(3);
    rst_n = 1'b1; idle(4);
  endtask

  task automatic t_reset();
    por_n = 0; rst_n = 0; sel_n = 1; dir = 0; step_n = 1;
    idle(6);
    por_n = 1; rst_n = 1; idle(4);
    check("R1 pos", int'(pos), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 standby", int'(standby), 0);
    check_tap("R6 reset tap", 0);
  endtask

  task automatic t_up_down();
    sel_n = 0; dir = 1; idle(4);
    pulses(5);
    check("R2 up", int'(pos), 5);
    check_tap("R6 tap5", 5);
    dir = 0; idle(4);
    pulses(2);
    check("R3 down", int'(pos), 3);
  endtask

  task automatic t_saturate();
    dir = 1; idle(4);
    pulses(110);
    check("R5 top", int'(pos), 99);
    check_tap("R6 tap99", 99);
    dir = 0; idle(4);
    pulses(110);
    check("R5 bottom", int'(pos), 0);
    dir = 1; idle(4);
    pulses(7);
    check("R2 to7", int'(pos), 7);
  endtask

  task automatic t_store_standby();
    int cnt = 0;
    sel_n = 1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (busy) begin
        cnt++;
        check("R9 no standby in busy", int'(standby), 0);
      end
    end
    check("R7 busy length", cnt, SC);
    check("R9 standby after save", int'(standby), 1);
    check("R7 pos kept", int'(pos), 7);
    pulses(3);
    check("R4 deselected steps", int'(pos), 7);
    check("R9 standby held", int'(standby), 1);
    sel_n = 0; idle(5);
    check("R9 standby cleared", int'(standby), 0);
  endtask

  task automatic t_no_store();
    int seen = 0;
    step_n = 0; idle(6);
    check("R2 fall to8", int'(pos), 8);
    sel_n = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check("R8 no busy", seen, 0);
    check("R8 no standby", int'(standby), 0);
    step_n = 1; idle(4);
    sel_n = 0; idle(5);
    check("R12 rise ignored", int'(pos), 8);
    warm_reset();
    check("R11 R8 reload old word", int'(pos), 7);
  endtask

  task automatic t_busy_lock();
    int waited = 0;
    sel_n = 0; dir = 1; idle(4);
    pulses(2);
    check("R2 to9", int'(pos), 9);
    sel_n = 1;
    while (!busy && waited < 20) begin
      @(negedge clk); waited++;
    end
    check("R7 busy seen", int'(busy), 1);
    sel_n = 0;
    pulse(2, 2);
    pulse(2, 2);
    waited = 0;
    while (busy && waited < 60) begin
      @(negedge clk); waited++;
    end
    idle(5);
    check("R10 steps in busy ignored", int'(pos), 9);
    check("R9 selected at end", int'(standby), 0);
    warm_reset();
    check("R11 R7 reload saved", int'(pos), 9);
  endtask

  initial begin
    t_reset();
    t_up_down();
    t_saturate();
    t_store_standby();
    t_no_store();
    t_busy_lock();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule